// File: doc/BRIEF.md
# Oversampled Serial Bit Timer

This block produces the sample and bit timing for the receive and transmit paths of a LIN or UART style serial port. A programmable prescaler divides the system clock into sample ticks, and a runtime-programmable samples-per-bit count groups those ticks into bit periods. On the receive side, three samples are taken around the middle of each bit. Their majority value is delivered together with a one-cycle valid strobe. On the transmit side, a one-cycle strobe marks each bit boundary.

The oversampling ratio is 32 by default. When the manual-override input is high, software supplies its own ratio. Any value below 8 is raised to 8. A start-of-frame pulse, which the surrounding logic raises on the falling edge that begins a frame, restarts the prescaler and the sample counter. This keeps bit centres aligned to that edge. The received-bit output is a valid-only stream with no ready signal: a serial line cannot be paused, so there is no back-pressure, and the consumer must accept every strobe in the cycle it appears. The RX input is expected to be synchronous to `clk` already.

Top module: `lin_bit_timer`

## Requirements
- R1: With divisor value N, sample ticks are spaced N+1 clock cycles apart. A bit period therefore lasts S*(N+1) cycles, where S is the effective samples-per-bit value.
- R2: While the override input is low, S is 32 and the samples-per-bit input has no effect on timing.
- R3: While the override input is high and the samples-per-bit input is 8 or more, S equals that input.
- R4: While the override input is high and the samples-per-bit input is below 8 (including 0), S is 8.
- R5: The received bit value is the majority of the RX line sampled at the ticks numbered h-1, h and h+1 of the bit, where h = floor(S/2) and ticks are numbered from 0 within the bit. A level inverted at exactly one of these ticks does not change the result, and a level inverted at two of them does.
- R6: When the start-of-frame pulse is high in the cycle before clock edge E0, all timing restarts from E0 whatever the previous phase. No strobe is high in the cycle following E0.
- R7: The bit-valid strobe is high for exactly one cycle, in the cycle that follows edge E0 + n*S*(N+1) + (h+2)*(N+1) for bit n = 0, 1, 2, and so on. It is low at all other times.
- R8: The bit-boundary strobe is high for exactly one cycle, in the cycle that follows edge E0 + (n+1)*S*(N+1). It is low at all other times.
- R9: While reset is asserted, and in the first cycle after it is released, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | 12 | Prescaler divisor N; divides the clock by N+1 |
| spb_i | input | 6 | Requested samples per bit; used only under override |
| ovr_i | input | 1 | Manual override: take the samples-per-bit value from spb_i |
| rx_i | input | 1 | Receive line, already synchronous to clk |
| sof_i | input | 1 | Start-of-frame pulse; restarts all timing |
| bit_vld_o | output | 1 | One-cycle strobe: bit_val_o holds a new received bit |
| bit_val_o | output | 1 | Majority-voted received bit value |
| bit_edge_o | output | 1 | One-cycle strobe at each bit boundary, for transmit |

## Verification
The hardest case to reach from the ports is a disturbance that hits exactly one, or exactly two, of the three vote ticks and no other sample. Those ticks move with both the divisor and the ratio. From each vector's divisor and effective ratio, the bench computes the edge index of every vote tick relative to the start-of-frame edge. It inverts the RX level only in the cycle before those edges. This is repeated for odd and even ratios, for the clamped floor, and for a divisor of zero, where the three votes fall on consecutive cycles.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int LBT_DIV_W       = 12;
  localparam int LBT_SPB_W       = 6;
  localparam int LBT_SPB_DEFAULT = 32;
  localparam int LBT_SPB_MIN     = 8;
  localparam int LBT_NVOTE       = 3;

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/lbt_prescaler.sv
module lbt_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the counter bounded if the divisor shrinks mid-count
  assign wrap   = (cnt_q >= div_i);
  assign tick_o = wrap && !sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (sync_i || wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0)); // R1

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/lbt_sample_seq.sv
module lbt_sample_seq #(
  parameter int SPB_W = 6,
  parameter int NVOTE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             tick_i,
  input  logic [SPB_W-1:0] spb_i,
  output logic [NVOTE-1:0] vote_o,
  output logic             bit_edge_o
);
  localparam int HALF_SPAN = NVOTE / 2;

  logic [SPB_W-1:0] cnt_q;
  logic [SPB_W-1:0] last_idx;
  logic [SPB_W-1:0] mid_idx;
  logic             end_of_bit;

  assign last_idx   = spb_i - SPB_W'(1);
  assign mid_idx    = spb_i >> 1;
  assign end_of_bit = (cnt_q >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (sync_i)    cnt_q <= '0;
    else if (tick_i)    cnt_q <= end_of_bit ? '0 : cnt_q + SPB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_edge_o <= 1'b0;
    else        bit_edge_o <= tick_i && end_of_bit;
  end

  // vote positions centred on the middle tick of the bit
  for (genvar j = 0; j < NVOTE; j++) begin : g_vote
    assign vote_o[j] = tick_i &&
      (cnt_q == mid_idx + SPB_W'(j) - SPB_W'(HALF_SPAN));
  end

  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_edge_o |=> !bit_edge_o); // R8

  AST_VOTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vote_o)); // R5

  AST_EDGE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_edge_o |-> $past(tick_i)); // R1
endmodule

// File: rtl/lbt_voter.sv
module lbt_voter #(
  parameter int NVOTE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [NVOTE-1:0] vote_i,
  output logic             bit_vld_o,
  output logic             bit_val_o
);
  import lbt_pkg::*;

  logic [NVOTE-2:0] smp_q;

  for (genvar j = 0; j < NVOTE - 1; j++) begin : g_smp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         smp_q[j] <= 1'b0;
      else if (vote_i[j]) smp_q[j] <= rx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_vld_o <= 1'b0;
      bit_val_o <= 1'b0;
    end else begin
      bit_vld_o <= vote_i[NVOTE-1];
      if (vote_i[NVOTE-1]) bit_val_o <= majority3(smp_q[0], smp_q[1], rx_i);
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |=> !bit_vld_o); // R7

  AST_VLD_AFTER_LAST_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> $past(vote_i[NVOTE-1])); // R7

  AST_VAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_i[NVOTE-1] |=> $stable(bit_val_o)); // R5
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int DIV_W       = lbt_pkg::LBT_DIV_W,
  parameter int SPB_W       = lbt_pkg::LBT_SPB_W,
  parameter int SPB_DEFAULT = lbt_pkg::LBT_SPB_DEFAULT,
  parameter int SPB_MIN     = lbt_pkg::LBT_SPB_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [SPB_W-1:0] spb_i,
  input  logic             ovr_i,
  input  logic             rx_i,
  input  logic             sof_i,
  output logic             bit_vld_o,
  output logic             bit_val_o,
  output logic             bit_edge_o
);
  localparam int NVOTE = lbt_pkg::LBT_NVOTE;
  localparam logic [SPB_W-1:0] SPB_DEF_V = SPB_W'(SPB_DEFAULT);
  localparam logic [SPB_W-1:0] SPB_MIN_V = SPB_W'(SPB_MIN);

  logic [SPB_W-1:0] spb_eff;
  logic             tick;
  logic [NVOTE-1:0] vote;

  // ratio selection: default unless overridden, floor applied to manual values
  always_comb begin
    if (!ovr_i)                 spb_eff = SPB_DEF_V;
    else if (spb_i < SPB_MIN_V) spb_eff = SPB_MIN_V;
    else                        spb_eff = spb_i;
  end

  lbt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sof_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  lbt_sample_seq #(.SPB_W(SPB_W), .NVOTE(NVOTE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sof_i),
    .tick_i     (tick),
    .spb_i      (spb_eff),
    .vote_o     (vote),
    .bit_edge_o (bit_edge_o)
  );

  lbt_voter #(.NVOTE(NVOTE)) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_i      (rx_i),
    .vote_i    (vote),
    .bit_vld_o (bit_vld_o),
    .bit_val_o (bit_val_o)
  );

  AST_SPB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    spb_eff >= SPB_MIN_V); // R4

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (!bit_vld_o && !bit_edge_o)); // R6

  AST_DEFAULT_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_i && bit_edge_o && !$past(sof_i)) |-> !$past(bit_edge_o)); // R2
endmodule

// File: tb/lin_bit_timer_test.sv
module lin_bit_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = '0;
  logic [5:0]  spb = '0;
  logic        ovr = 1'b0;
  logic        rx = 1'b1;
  logic        sof = 1'b0;
  logic        bit_vld, bit_val, bit_edge;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lin_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .div_i(div), .spb_i(spb), .ovr_i(ovr),
    .rx_i(rx), .sof_i(sof),
    .bit_vld_o(bit_vld), .bit_val_o(bit_val), .bit_edge_o(bit_edge)
  );

  // {div[12], spb[6], ovr[1], glitch mode[2], pattern[4]}
  // mode 0: clean, 1: one vote inverted, 2: two votes inverted
  localparam int NV = 7;
  localparam logic [24:0] VEC [NV] = '{
    {12'd3, 6'd20, 1'b0, 2'd0, 4'b1010},  // R2: spb ignored, S=32
    {12'd0, 6'd8,  1'b1, 2'd1, 4'b0110},  // R3: floor value exact
    {12'd2, 6'd3,  1'b1, 2'd0, 4'b1101},  // R4: clamp to 8
    {12'd1, 6'd63, 1'b1, 2'd1, 4'b1001},  // R3: maximum, odd
    {12'd0, 6'd13, 1'b1, 2'd2, 4'b0011},  // R3: odd ratio, R5 two votes
    {12'd5, 6'd16, 1'b1, 2'd0, 4'b0101},  // R1: larger divisor
    {12'd0, 6'd0,  1'b1, 2'd2, 4'b1110}   // R4: zero clamps to 8
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int dv, input int raw, input bit ov,
                          input int mode, input logic [3:0] pat, input int edges);
    int s, d, h, per;
    string tg;
    s   = !ov ? 32 : (raw < 8 ? 8 : raw);
    d   = dv + 1;
    h   = s / 2;
    per = s * d;
    tg  = !ov ? "R2" : (raw < 8 ? "R4" : "R3");
    @(negedge clk);
    div = 12'(dv); spb = 6'(raw); ovr = ov; sof = 1'b1;
    @(posedge clk); #1;  // edge E0
    for (int e = 1; e <= edges; e++) begin
      int k, b;
      logic lvl;
      bit exp_vld, exp_edge;
      @(negedge clk);
      sof = 1'b0;
      k = e / d - 1;
      b = (k < 0) ? 0 : k / s;
      lvl = pat[b % 4];
      if (e % d == 0 && k >= 0) begin
        if (mode == 1 && (k % s) == h) lvl = ~lvl;
        if (mode == 2 && ((k % s) == h - 1 || (k % s) == h)) lvl = ~lvl;
      end
      rx = lvl;
      @(posedge clk); #1;
      exp_vld  = ((e % per) == (h + 2) * d);
      exp_edge = ((e % per) == 0);
      chk(bit_vld === exp_vld, {"R7 vld timing ", tg}, int'(bit_vld), int'(exp_vld));
      chk(bit_edge === exp_edge, {"R8/R1/R6 edge timing ", tg}, int'(bit_edge), int'(exp_edge));
      if (exp_vld) begin
        logic ev;
        ev = pat[(e / per) % 4] ^ (mode == 2);
        chk(bit_val === ev, "R5 majority value", int'(bit_val), int'(ev));
      end
    end
  endtask

  initial begin
    #600000;  // watchdog, 150k cycles
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: strobes low under reset and just after release
    repeat (3) @(posedge clk);
    #1;
    chk(bit_vld === 1'b0 && bit_edge === 1'b0, "R9 during reset",
        int'({bit_vld, bit_edge}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(bit_vld === 1'b0 && bit_edge === 1'b0, "R9 after release",
        int'({bit_vld, bit_edge}), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      int dv, raw, s;
      dv  = int'(VEC[i][24:13]);
      raw = int'(VEC[i][12:7]);
      s   = !VEC[i][6] ? 32 : (raw < 8 ? 8 : raw);
      run_case(dv, raw, VEC[i][6], int'(VEC[i][5:4]), VEC[i][3:0], 4 * s * (dv + 1) + 2);
    end

    // R6: restart in mid-bit, then a fresh frame with different timing
    run_case(2, 10, 1'b1, 0, 4'b1011, 10 * 3 + 7);
    run_case(0, 9, 1'b1, 1, 4'b0100, 4 * 9 + 2);
    // R1: large divisors
    run_case(300, 8, 1'b1, 1, 4'b0110, 2 * 8 * 301 + 2);
    run_case(4095, 8, 1'b1, 0, 4'b0001, 8 * 4096 + 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule